// File: doc/BRIEF.md
# Configurable Logic-Array Macrocell

This block is one output cell of a programmable logic array. It takes the sum-of-products result of the array and either registers it or passes it straight through, then drives an output pin model with a selectable output enable. The storage element works as a D flip-flop, as a T flip-flop, or is bypassed for a purely combinational output. All configuration inputs are static: they are set while the cell is held in reset and do not change during operation.

The register clock comes from one of the global clocks, each usable on either edge, or from one of two control-term clocks. Two control terms act as asynchronous clear and preset, and this function can be switched off. The output enable comes from one of four control terms, or is forced on or off. A global active-low tri-state input overrides the enable. Two feedback signals return to the array. One is the macrocell value taken before the output buffer. The other is the pin value taken after the buffer.

Top module: `cpld_macrocell`

## Requirements
- R1: With `cfg_mode` = 0 (D), the macrocell value takes the value of `sop_in` at each active edge of the selected clock and holds it between edges.
- R2: With `cfg_mode` = 1 (T), the macrocell value inverts at an active edge when `sop_in` is 1 and holds when it is 0.
- R3: With `cfg_mode` = 2 or 3 (combinational), `mc_fb` follows `sop_in` with no clock edge needed.
- R4: `cfg_clk_sel` values 0 to NUM_GCLK-1 pick global clock `gclk[i]`. NUM_GCLK picks control term 2 (`ct_in[2]`) and larger values pick control term 3 (`ct_in[3]`), both on their rising edge. Edges on clocks that are not selected do not change the value.
- R5: A selected global clock `gclk[i]` is active on its rising edge when `cfg_clk_neg[i]` is 0 and on its falling edge when it is 1.
- R6: With `cfg_init_en` = 1, a high `ct_in[0]` forces the register to 0 and a high `ct_in[1]` forces it to 1, with no clock needed. When both are high the register is 0. When the clear is released while the preset is still high, the register goes to 1.
- R7: With `cfg_init_en` = 0, `ct_in[0]` and `ct_in[1]` have no effect on the register.
- R8: While `rst_n` is low, the register is 0.
- R9: The `cfg_oe_sel` encoding is: 0 picks `ct_in[2]`, 1 `ct_in[3]`, 2 `ct_in[4]`, 3 `ct_in[5]`, 4 always enabled, and 5 to 7 always disabled.
- R10: When `cfg_gts_en` = 1 and `gts_n` = 0, `pin_oe` is 0 whatever the other settings are.
- R11: `pin_out` and `mc_fb` both carry the macrocell value. `pin_fb` equals the macrocell value while `pin_oe` is 1 and equals `pin_ext` while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low, clears the register |
| gclk | input | NUM_GCLK | Global clocks |
| ct_in | input | 6 | Control terms from the array (clear, preset, clocks, enables) |
| sop_in | input | 1 | Sum-of-products data input |
| cfg_mode | input | 2 | 0 = D, 1 = T, 2 or 3 = combinational |
| cfg_clk_sel | input | $clog2(NUM_GCLK+2) | Clock source select |
| cfg_clk_neg | input | NUM_GCLK | Per global clock: 1 selects the falling edge |
| cfg_init_en | input | 1 | Enables control-term clear and preset |
| cfg_oe_sel | input | 3 | Output-enable source select |
| cfg_gts_en | input | 1 | Enables the global tri-state input |
| gts_n | input | 1 | Global tri-state, active low |
| pin_ext | input | 1 | Value driven on the pin from outside |
| pin_out | output | 1 | Data toward the output buffer |
| pin_oe | output | 1 | Output buffer enable |
| mc_fb | output | 1 | Macrocell feedback, taken before the buffer |
| pin_fb | output | 1 | Pin feedback, taken after the buffer |

## Verification
The bench targets falling-edge selection. A design that ignored the polarity bit would capture half a period off, and the macrocell value would differ after every falling edge. It drives clear and preset together and releases them in turn. A cell whose preset won, or whose preset was only edge-triggered, would show 1 while the clear is held, or would stay at 0 after the clear drops. Edges arrive on every clock at once, so a wrong source decode shows up as captures on the wrong clock. The global tri-state is pulled low during the forced-on enable setting, and tri-stated cycles check that the pin feedback switches to the external value.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_D    = 2'd0,
    MODE_T    = 2'd1,
    MODE_COMB = 2'd2,
    MODE_CMB2 = 2'd3
  } mc_mode_e;

  localparam int NUM_CT      = 6;
  localparam int OE_SEL_W    = 3;
  localparam logic [OE_SEL_W-1:0] OE_CT2 = 3'd0;
  localparam logic [OE_SEL_W-1:0] OE_CT3 = 3'd1;
  localparam logic [OE_SEL_W-1:0] OE_CT4 = 3'd2;
  localparam logic [OE_SEL_W-1:0] OE_CT5 = 3'd3;
  localparam logic [OE_SEL_W-1:0] OE_ON  = 3'd4;
endpackage

// File: rtl/mc_dom_flop.sv
`timescale 1ns/1ps
module mc_dom_flop #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic aclr,
  input  logic aset,
  input  logic t_mode,
  input  logic d_in,
  output logic q
);
  logic aset_eff;
  logic nxt;
  logic fresh;

  // clear dominates; masking the set makes its release from clear an event
  assign aset_eff = aset & ~aclr;

  always_comb begin
    nxt = t_mode ? (q ^ d_in) : d_in;
  end

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk or posedge aclr or posedge aset_eff) begin
        if (aclr)          q <= 1'b0;
        else if (aset_eff) q <= 1'b1;
        else               q <= nxt;
      end
      always_ff @(negedge clk or posedge aclr or posedge aset_eff) begin
        if (aclr || aset_eff) fresh <= 1'b0;
        else                  fresh <= 1'b1;
      end
      assert_d_capture_R1: assert property (@(negedge clk) disable iff (aclr || aset_eff)
        !t_mode |=> (!fresh || q == $past(d_in)));
      assert_t_toggle_R2: assert property (@(negedge clk) disable iff (aclr || aset_eff)
        t_mode |=> (!fresh || q == ($past(q) ^ $past(d_in))));
      assert_clear_hold_R6: assert property (@(negedge clk) aclr |-> !q);
      assert_preset_hold_R6: assert property (@(negedge clk) aset_eff |-> q);
    end else begin : g_rise
      always_ff @(posedge clk or posedge aclr or posedge aset_eff) begin
        if (aclr)          q <= 1'b0;
        else if (aset_eff) q <= 1'b1;
        else               q <= nxt;
      end
      always_ff @(posedge clk or posedge aclr or posedge aset_eff) begin
        if (aclr || aset_eff) fresh <= 1'b0;
        else                  fresh <= 1'b1;
      end
      assert_d_capture_R1: assert property (@(posedge clk) disable iff (aclr || aset_eff)
        !t_mode |=> (!fresh || q == $past(d_in)));
      assert_t_toggle_R2: assert property (@(posedge clk) disable iff (aclr || aset_eff)
        t_mode |=> (!fresh || q == ($past(q) ^ $past(d_in))));
      assert_clear_hold_R6: assert property (@(posedge clk) aclr |-> !q);
      assert_preset_hold_R6: assert property (@(posedge clk) aset_eff |-> q);
    end
  endgenerate
endmodule

// File: rtl/mc_clk_bank.sv
`timescale 1ns/1ps
module mc_clk_bank #(
  parameter int NUM_GCLK = 4,
  parameter int SEL_W    = 3
) (
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [1:0]          ct_clk,
  input  logic                init_en,
  input  logic                ct_clr,
  input  logic                ct_set,
  input  logic                t_mode,
  input  logic                d_in,
  input  logic [SEL_W-1:0]    clk_sel,
  input  logic [NUM_GCLK-1:0] clk_neg,
  output logic                q_sel
);
  logic                aclr;
  logic                aset;
  logic [NUM_GCLK-1:0] q_pos;
  logic [NUM_GCLK-1:0] q_neg;
  logic [1:0]          q_ct;

  assign aclr = ~rst_n | (init_en & ct_clr);
  assign aset = init_en & ct_set;

  // one storage flop per clock domain and edge; no logic on any clock path
  for (genvar i = 0; i < NUM_GCLK; i++) begin : g_glob
    mc_dom_flop #(.FALLING(1'b0)) u_pos (
      .clk(gclk[i]), .aclr(aclr), .aset(aset), .t_mode(t_mode),
      .d_in(d_in), .q(q_pos[i]));
    mc_dom_flop #(.FALLING(1'b1)) u_neg (
      .clk(gclk[i]), .aclr(aclr), .aset(aset), .t_mode(t_mode),
      .d_in(d_in), .q(q_neg[i]));
  end

  for (genvar j = 0; j < 2; j++) begin : g_ct
    mc_dom_flop #(.FALLING(1'b0)) u_ct (
      .clk(ct_clk[j]), .aclr(aclr), .aset(aset), .t_mode(t_mode),
      .d_in(d_in), .q(q_ct[j]));
  end

  always_comb begin
    q_sel = q_ct[1];
    if (clk_sel == SEL_W'(NUM_GCLK)) q_sel = q_ct[0];
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (clk_sel == SEL_W'(i)) q_sel = clk_neg[i] ? q_neg[i] : q_pos[i];
    end
  end
endmodule

// File: rtl/mc_out_buf.sv
`timescale 1ns/1ps
module mc_out_buf
  import mc_pkg::*;
(
  input  logic [3:0]          ct_oe,
  input  logic [OE_SEL_W-1:0] oe_sel,
  input  logic                gts_en,
  input  logic                gts_n,
  input  logic                mc_val,
  input  logic                pin_ext,
  output logic                pin_out,
  output logic                pin_oe,
  output logic                pin_fb
);
  logic oe_pick;

  always_comb begin
    case (oe_sel)
      OE_CT2:  oe_pick = ct_oe[0];
      OE_CT3:  oe_pick = ct_oe[1];
      OE_CT4:  oe_pick = ct_oe[2];
      OE_CT5:  oe_pick = ct_oe[3];
      OE_ON:   oe_pick = 1'b1;
      default: oe_pick = 1'b0;
    endcase
  end

  assign pin_oe  = oe_pick & ~(gts_en & ~gts_n);
  assign pin_out = mc_val;
  assign pin_fb  = pin_oe ? mc_val : pin_ext;
endmodule

// File: rtl/cpld_macrocell.sv
`timescale 1ns/1ps
module cpld_macrocell
  import mc_pkg::*;
#(
  parameter int NUM_GCLK = 4,
  localparam int SEL_W = $clog2(NUM_GCLK + 2)
) (
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [NUM_CT-1:0]   ct_in,
  input  logic                sop_in,
  input  logic [1:0]          cfg_mode,
  input  logic [SEL_W-1:0]    cfg_clk_sel,
  input  logic [NUM_GCLK-1:0] cfg_clk_neg,
  input  logic                cfg_init_en,
  input  logic [OE_SEL_W-1:0] cfg_oe_sel,
  input  logic                cfg_gts_en,
  input  logic                gts_n,
  input  logic                pin_ext,
  output logic                pin_out,
  output logic                pin_oe,
  output logic                mc_fb,
  output logic                pin_fb
);
  logic q_reg;
  logic is_comb;
  logic t_mode;
  logic mc_val;

  assign is_comb = (cfg_mode == MODE_COMB) || (cfg_mode == MODE_CMB2);
  assign t_mode  = (cfg_mode == MODE_T);

  mc_clk_bank #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_bank (
    .rst_n(rst_n), .gclk(gclk), .ct_clk(ct_in[3:2]), .init_en(cfg_init_en),
    .ct_clr(ct_in[0]), .ct_set(ct_in[1]), .t_mode(t_mode), .d_in(sop_in),
    .clk_sel(cfg_clk_sel), .clk_neg(cfg_clk_neg), .q_sel(q_reg));

  assign mc_val = is_comb ? sop_in : q_reg;
  assign mc_fb  = mc_val;

  mc_out_buf u_obuf (
    .ct_oe(ct_in[5:2]), .oe_sel(cfg_oe_sel), .gts_en(cfg_gts_en), .gts_n(gts_n),
    .mc_val(mc_val), .pin_ext(pin_ext), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_fb(pin_fb));

  assert_comb_follow_R3: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    is_comb |-> (mc_fb == sop_in));
  assert_gts_override_R10: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    (cfg_gts_en && !gts_n) |-> !pin_oe);
  assert_oe_off_R9: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    (cfg_oe_sel > OE_ON) |-> !pin_oe);
  assert_oe_on_R9: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    (cfg_oe_sel == OE_ON && !(cfg_gts_en && !gts_n)) |-> pin_oe);
  assert_pin_fb_R11: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    pin_fb == (pin_oe ? mc_fb : pin_ext));
endmodule

// File: tb/test_cpld_macrocell.sv
`timescale 1ns/1ps
module test_cpld_macrocell;
  localparam int NG = 4;
  localparam int SW = $clog2(NG + 2);

  logic          clk;
  logic          rst_n;
  logic [NG-1:0] gclk;
  logic [5:0]    ct_in;
  logic          sop_in;
  logic [1:0]    cfg_mode;
  logic [SW-1:0] cfg_clk_sel;
  logic [NG-1:0] cfg_clk_neg;
  logic          cfg_init_en;
  logic [2:0]    cfg_oe_sel;
  logic          cfg_gts_en;
  logic          gts_n;
  logic          pin_ext;
  logic          pin_out, pin_oe, mc_fb, pin_fb;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  bit  exp_q  = 0;

  cpld_macrocell #(.NUM_GCLK(NG)) i_cpld_macrocell (
    .rst_n(rst_n), .gclk(gclk), .ct_in(ct_in), .sop_in(sop_in), .cfg_mode(cfg_mode),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clk_neg(cfg_clk_neg), .cfg_init_en(cfg_init_en),
    .cfg_oe_sel(cfg_oe_sel), .cfg_gts_en(cfg_gts_en), .gts_n(gts_n), .pin_ext(pin_ext),
    .pin_out(pin_out), .pin_oe(pin_oe), .mc_fb(mc_fb), .pin_fb(pin_fb));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_oe(input bit [5:0] c, input bit gn);
    bit e;
    case (cfg_oe_sel)
      3'd0: e = c[2];
      3'd1: e = c[3];
      3'd2: e = c[4];
      3'd3: e = c[5];
      3'd4: e = 1'b1;
      default: e = 1'b0;
    endcase
    if (cfg_gts_en && !gn) e = 1'b0;
    return e;
  endfunction

  // one stimulus step: data and levels first, then clocks, then compare
  task automatic step(input bit [NG-1:0] g, input bit [5:0] c, input bit s,
                      input bit gn, input bit pe, input bit rn);
    bit [NG-1:0] pg;
    bit [5:0]    pc;
    bit          frc, edge_hit, oe, mv, old_v, new_v;
    int          sel;
    string       tag;
    @(posedge clk);
    pg = gclk; pc = ct_in;
    sel = int'(cfg_clk_sel);
    sop_in = s; gts_n = gn; pin_ext = pe; rst_n = rn;
    ct_in[0] = c[0]; ct_in[1] = c[1]; ct_in[4] = c[4]; ct_in[5] = c[5];
    if (!rn)                        tag = "R8";
    else if (cfg_mode[1])           tag = "R3";
    else if (cfg_init_en && (c[0] || c[1])) tag = "R6";
    else if (!cfg_init_en && (c[0] || c[1])) tag = "R7";
    else if (sel >= NG)             tag = "R4";
    else if (cfg_clk_neg[sel])      tag = "R5";
    else if (cfg_mode == 2'd1)      tag = "R2";
    else                            tag = "R1";
    frc = 1'b0;
    if (!rn)                        begin exp_q = 1'b0; frc = 1'b1; end
    else if (cfg_init_en && c[0])   begin exp_q = 1'b0; frc = 1'b1; end
    else if (cfg_init_en && c[1])   begin exp_q = 1'b1; frc = 1'b1; end
    #3;
    gclk = g; ct_in[2] = c[2]; ct_in[3] = c[3];
    if (sel < NG) begin
      old_v = pg[sel]; new_v = g[sel];
      edge_hit = cfg_clk_neg[sel] ? (old_v && !new_v) : (!old_v && new_v);
    end else if (sel == NG) edge_hit = !pc[2] && c[2];
    else                    edge_hit = !pc[3] && c[3];
    if (edge_hit && !frc) exp_q = (cfg_mode == 2'd1) ? (exp_q ^ s) : s;
    #3;
    mv = cfg_mode[1] ? s : exp_q;
    oe = exp_oe(c, gn);
    chk(tag, "mc_fb", mc_fb, mv);
    chk((cfg_gts_en && !gn) ? "R10" : "R9", "pin_oe", pin_oe, oe);
    chk("R11", "pin_out", pin_out, mv);
    chk("R11", "pin_fb", pin_fb, oe ? mv : pe);
  endtask

  task automatic configure(input bit [1:0] m, input int sel, input bit [NG-1:0] neg,
                           input bit ie, input bit [2:0] oes, input bit ge);
    step(gclk, ct_in, 1'b0, 1'b1, 1'b0, 1'b0);
    cfg_mode = m; cfg_clk_sel = SW'(sel); cfg_clk_neg = neg;
    cfg_init_en = ie; cfg_oe_sel = oes; cfg_gts_en = ge;
    step(gclk, ct_in, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h1F3A_77C5));
    rst_n = 1'b1; gclk = '0; ct_in = '0; sop_in = 1'b0; gts_n = 1'b1; pin_ext = 1'b0;
    cfg_mode = 2'd0; cfg_clk_sel = '0; cfg_clk_neg = '0; cfg_init_en = 1'b0;
    cfg_oe_sel = 3'd4; cfg_gts_en = 1'b0;
    #1 rst_n = 1'b0;
    // R8: reset state
    step(4'h0, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    step(4'h1, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    // R1: rising gclk0 captures after release
    step(4'h0, 6'h00, 1'b1, 1'b1, 1'b0, 1'b1);
    step(4'h1, 6'h00, 1'b1, 1'b1, 1'b0, 1'b1);
    // R5: falling edge of gclk2
    configure(2'd0, 2, 4'b0100, 1'b1, 3'd4, 1'b1);
    step(4'h4, 6'h00, 1'b1, 1'b1, 1'b1, 1'b1);
    step(4'h0, 6'h00, 1'b1, 1'b1, 1'b1, 1'b1);
    // R6: clear and preset together, then clear released first
    step(4'h0, 6'h03, 1'b1, 1'b1, 1'b0, 1'b1);
    step(4'h0, 6'h02, 1'b0, 1'b1, 1'b0, 1'b1);
    step(4'h0, 6'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    // R10: global tri-state against forced-on enable
    step(4'h0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    // R4: control-term clock ct3 (sel 5) in T mode
    configure(2'd1, 5, 4'h0, 1'b0, 3'd1, 1'b0);
    step(4'hF, 6'h08, 1'b1, 1'b1, 1'b0, 1'b1);
    step(4'h0, 6'h00, 1'b1, 1'b1, 1'b0, 1'b1);
    step(4'h0, 6'h0B, 1'b1, 1'b1, 1'b1, 1'b1);
    // random configurations
    for (int k = 0; k < 60; k++) begin
      configure(2'($urandom_range(0, 3)), $urandom_range(0, 5), NG'($urandom),
                1'($urandom), 3'($urandom_range(0, 7)), 1'($urandom));
      for (int n = 0; n < 40; n++) begin
        bit [5:0] c;
        c = 6'($urandom);
        c[0] = ($urandom_range(0, 5) == 0);
        c[1] = ($urandom_range(0, 5) == 0);
        step(NG'($urandom), c, 1'($urandom), ($urandom_range(0, 3) != 0),
             1'($urandom), 1'b1);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule